// File: doc/BRIEF.md
# Clock Autogating and Idle Handshake Controller

This block decides when the interface clock and the functional clock of a card-interface host controller may run. It drives clock-enable signals and an idle acknowledge. The gating cells and the power-domain switches sit outside the block.

In run mode the block counts consecutive quiet cycles, but only while the autoidle configuration bit is set. Once the count reaches a parameterised limit (8 by default), both clock enables drop. Any of three wake events ends the gated state: a register access from the interconnect, a card interrupt, or the start of a card transfer. While the block is gated, a register access still gets the interface clock in its own cycle, because interconnect accesses are the only traffic served in that state.

The block is always in exactly one of two modes, run or idle. It enters idle mode through a request/acknowledge handshake with the system power manager. Acknowledge is held back while a command or data transfer is in progress. Both clocks stay off for as long as acknowledge is high.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: During reset and on leaving it, iclk_en and fclk_en are 1 and idle_ack is 0, with the quiet-cycle count at zero.
- R2: While autoidle_en is 0, the clock enables never drop in run mode, however long the block is quiet.
- R3: With autoidle_en at 1, a cycle counts as quiet when reg_access, card_irq, xfer_start, busy and idle_req are all 0. fclk_en and iclk_en drop after the clock edge that ends the 8th consecutive quiet cycle (IDLE_CYCLES), and not earlier.
- R4: A reg_access in a cycle ends gating. Both enables are 1 from the next cycle on, and the quiet count starts again from zero.
- R5: A card_irq in a cycle ends gating in the same way as R4.
- R6: An xfer_start in a cycle ends gating in the same way as R4.
- R7: While gated, a cycle with reg_access at 1 has iclk_en at 1 in that same cycle while fclk_en stays 0. fclk_en at 1 always implies iclk_en at 1.
- R8: In run mode, idle_req at 1 with busy and xfer_start at 0 makes idle_ack 1 from the next cycle. While idle_ack is 1, both enables are 0.
- R9: While busy or xfer_start is 1, idle_ack stays 0. It rises in the cycle after the first cycle in which idle_req is 1 and both are 0.
- R10: When idle_req is 0 while idle_ack is 1, idle_ack is 0 from the next cycle on. Both enables return to 1 in that same cycle, with the quiet count restarted.
- R11: busy at 1 counts as activity. It keeps the quiet count at zero and ends gating like R4.
- R12: In idle mode, reg_access, card_irq and xfer_start do not raise either enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| autoidle_en | input | 1 | Configuration bit that allows autogating |
| reg_access | input | 1 | Interconnect register access strobe |
| card_irq | input | 1 | Wake-up interrupt from the card |
| xfer_start | input | 1 | A card-interface transfer starts this cycle |
| busy | input | 1 | A command or data transfer is in progress |
| idle_req | input | 1 | Idle request from the power manager |
| iclk_en | output | 1 | Interface clock enable |
| fclk_en | output | 1 | Functional clock enable |
| idle_ack | output | 1 | Idle acknowledge to the power manager |

## Verification
The assertions check the following on every cycle:
- both clocks are off while acknowledge is high;
- acknowledge is held back during a busy request;
- acknowledge is released one cycle after the request falls;
- the functional clock returns one cycle after any wake event, and whenever autoidle is off;
- the functional enable never runs without the interface enable.

Only the bench scenarios can show the exact quiet-cycle threshold, the restart of the count after each wake source, and the single-cycle interface-clock grant for a register access while gated. They also show that wake events seen in idle mode leave the clocks off.

// File: rtl/pwr_clk_pkg.sv
// Package: shared types for the clock autogating controller.
// Assumes: two power modes only; run and idle are mutually exclusive.
package pwr_clk_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_IDLE = 1'b1
    } pwr_mode_t;
endpackage

// File: rtl/quiet_timer.sv
// Module: quiet_timer
// Counts consecutive quiet cycles up to LIMIT and saturates there.
// Assumes: clear has priority over counting; expired is high once LIMIT is reached.
module quiet_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Count quiet cycles, restart on clear, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the saturated count.
    always_comb begin
        expired = (cnt_q == LIMIT_V);
    end
endmodule

// File: rtl/idle_handshake.sv
// Module: idle_handshake
// Run/idle mode machine for the power manager request/acknowledge handshake.
// Assumes: entry is refused while a transfer is busy or starting; exit follows request removal.
module idle_handshake
    import pwr_clk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_req,
    input  logic      busy,
    input  logic      xfer_start,
    output pwr_mode_t mode
);
    pwr_mode_t mode_q;
    pwr_mode_t mode_d;

    // Next-mode decision.
    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            MODE_RUN:  if (idle_req && !busy && !xfer_start) mode_d = MODE_IDLE;
            MODE_IDLE: if (!idle_req) mode_d = MODE_RUN;
            default:   mode_d = MODE_RUN;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Expose the current mode.
    always_comb begin
        mode = mode_q;
    end
endmodule

// File: rtl/clk_enable_gen.sv
// Module: clk_enable_gen
// Derives the two clock enables from the mode and the quiet timer.
// Assumes: a register access while gated needs the interface clock in its own cycle.
module clk_enable_gen
    import pwr_clk_pkg::*;
(
    input  pwr_mode_t mode,
    input  logic      expired,
    input  logic      reg_access,
    output logic      iclk_en,
    output logic      fclk_en
);
    // Enables are off in idle mode; when gated, only an access opens the interface clock.
    always_comb begin
        if (mode == MODE_IDLE) begin
            fclk_en = 1'b0;
            iclk_en = 1'b0;
        end else begin
            fclk_en = !expired;
            iclk_en = !expired || reg_access;
        end
    end
endmodule

// File: rtl/pwr_clk_ctrl.sv
// Module: pwr_clk_ctrl (top)
// Clock autogating in run mode plus the idle request/acknowledge handshake.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module pwr_clk_ctrl
    import pwr_clk_pkg::*;
#(
    parameter int IDLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic autoidle_en,
    input  logic reg_access,
    input  logic card_irq,
    input  logic xfer_start,
    input  logic busy,
    input  logic idle_req,
    output logic iclk_en,
    output logic fclk_en,
    output logic idle_ack
);
    pwr_mode_t mode;
    logic      activity;
    logic      timer_clear;
    logic      expired;

    // Any wake source or running transfer counts as activity.
    always_comb begin
        activity    = reg_access || card_irq || xfer_start || busy;
        timer_clear = activity || !autoidle_en || idle_req || (mode == MODE_IDLE);
    end

    quiet_timer #(.LIMIT(IDLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .expired (expired)
    );

    idle_handshake u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_req   (idle_req),
        .busy       (busy),
        .xfer_start (xfer_start),
        .mode       (mode)
    );

    clk_enable_gen u_en (
        .mode       (mode),
        .expired    (expired),
        .reg_access (reg_access),
        .iclk_en    (iclk_en),
        .fclk_en    (fclk_en)
    );

    // Acknowledge reflects idle mode.
    always_comb begin
        idle_ack = (mode == MODE_IDLE);
    end
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
// Module: pwr_clk_ctrl_chk
// Port-level property checker for pwr_clk_ctrl, attached by bind.
// Assumes: all properties are disabled during reset.
module pwr_clk_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic autoidle_en,
    input logic reg_access,
    input logic card_irq,
    input logic xfer_start,
    input logic busy,
    input logic idle_req,
    input logic iclk_en,
    input logic fclk_en,
    input logic idle_ack
);
    AST_ACK_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ack |-> (!fclk_en && !iclk_en)); // R8
    AST_ACK_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && busy && !idle_ack) |=> !idle_ack); // R9
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack && !idle_req) |=> (!idle_ack && fclk_en && iclk_en)); // R10
    AST_WAKE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_access || card_irq || xfer_start) && !idle_ack && !idle_req) |=> fclk_en); // R4
    AST_NO_AUTOGATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!autoidle_en && !idle_ack && !idle_req) |=> fclk_en); // R2
    AST_FCLK_NEEDS_ICLK: assert property (@(posedge clk) disable iff (!rst_n)
        fclk_en |-> iclk_en); // R7
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .autoidle_en (autoidle_en),
    .reg_access  (reg_access),
    .card_irq    (card_irq),
    .xfer_start  (xfer_start),
    .busy        (busy),
    .idle_req    (idle_req),
    .iclk_en     (iclk_en),
    .fclk_en     (fclk_en),
    .idle_ack    (idle_ack)
);

// File: tb/pwr_clk_ctrl_tb_top.sv
// Bench for pwr_clk_ctrl: behavioural reference model compared every cycle.
module pwr_clk_ctrl_tb_top;
    localparam int LIMIT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic autoidle_en = 1'b0, reg_access = 1'b0, card_irq = 1'b0;
    logic xfer_start = 1'b0, busy = 1'b0, idle_req = 1'b0;
    logic iclk_en, fclk_en, idle_ack;

    int checks = 0;
    int failures = 0;
    int m_quiet = 0;
    bit m_idle = 1'b0;

    always #4 clk = ~clk;

    pwr_clk_ctrl #(.IDLE_CYCLES(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .autoidle_en(autoidle_en),
        .reg_access(reg_access), .card_irq(card_irq), .xfer_start(xfer_start),
        .busy(busy), .idle_req(idle_req),
        .iclk_en(iclk_en), .fclk_en(fclk_en), .idle_ack(idle_ack)
    );

    task automatic compare(input string tag);
        bit gated;
        bit e_f, e_i, e_a;
        gated = !m_idle && (m_quiet >= LIMIT);
        e_f = !m_idle && !gated;
        e_i = !m_idle && (!gated || reg_access);
        e_a = m_idle;
        checks++;
        if (fclk_en !== e_f || iclk_en !== e_i || idle_ack !== e_a) begin
            failures++;
            $display("FAIL %s: actual f=%b i=%b ack=%b expected f=%b i=%b ack=%b",
                     tag, fclk_en, iclk_en, idle_ack, e_f, e_i, e_a);
        end
    endtask

    task automatic model_update();
        bit act;
        act = reg_access || card_irq || xfer_start || busy;
        if (m_idle) begin
            if (!idle_req) m_idle = 1'b0;
            m_quiet = 0;
        end else if (idle_req && !busy && !xfer_start) begin
            m_idle = 1'b1;
            m_quiet = 0;
        end else if (act || !autoidle_en || idle_req) begin
            m_quiet = 0;
        end else if (m_quiet < LIMIT) begin
            m_quiet++;
        end
    endtask

    // One cycle: drive at the falling edge, check, then advance the model at the rising edge.
    task automatic step(input bit ae, input bit ra, input bit ci, input bit xs,
                        input bit bz, input bit rq, input string tag);
        @(negedge clk);
        autoidle_en = ae; reg_access = ra; card_irq = ci;
        xfer_start = xs; busy = bz; idle_req = rq;
        #1;
        compare(tag);
        @(posedge clk);
        model_update();
    endtask

    task automatic quiet(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        compare("R1 reset");
        rst_n = 1'b1;
        @(posedge clk);
        // R1 just after reset
        step(0, 0, 0, 0, 0, 0, "R1 after reset");
        // R2 autoidle off: never gates
        for (int k = 0; k < 12; k++) step(0, 0, 0, 0, 0, 0, "R2 no autogate");
        // R3 threshold at 8 quiet cycles
        quiet(11, "R3 threshold");
        // R7 access while gated, then R4 wake
        step(1, 1, 0, 0, 0, 0, "R7 access grant");
        quiet(3, "R4 after access");
        quiet(7, "R4 regate");
        // R5 card interrupt wake
        step(1, 0, 1, 0, 0, 0, "R5 card irq");
        quiet(10, "R5 after irq");
        // R6 transfer start wake
        step(1, 0, 0, 1, 0, 0, "R6 xfer start");
        quiet(9, "R6 after xfer");
        // R11 busy keeps clocks on
        for (int k = 0; k < 12; k++) step(1, 0, 0, 0, 1, 0, "R11 busy");
        quiet(9, "R11 after busy");
        // R8 idle entry with no transfer
        step(1, 0, 0, 0, 0, 1, "R8 request");
        step(1, 0, 0, 0, 0, 1, "R8 acked");
        // R12 wake sources ignored in idle
        step(1, 1, 0, 0, 0, 1, "R12 access in idle");
        step(1, 0, 1, 0, 0, 1, "R12 irq in idle");
        step(1, 0, 0, 1, 0, 1, "R12 xfer in idle");
        // R10 release
        step(1, 0, 0, 0, 0, 0, "R10 release");
        step(1, 0, 0, 0, 0, 0, "R10 restored");
        quiet(4, "R10 count restart");
        // R9 request while busy
        for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 1, 1, "R9 busy withheld");
        step(1, 0, 0, 1, 0, 1, "R9 xfer withheld");
        step(1, 0, 0, 0, 0, 1, "R9 free");
        step(1, 0, 0, 0, 0, 1, "R9 acked");
        step(1, 0, 0, 0, 0, 0, "R10 drop");
        quiet(10, "R3 second gate");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule